// File: doc/BRIEF.md
# DDR Write Command Timing Scheduler

This block sits on the controller side of a double-data-rate SDRAM interface. It takes one request at a time over a valid/ready handshake. A request is a WRITE, a READ or a PRECHARGE, and it carries a bank, a column and an auto-precharge flag. The block puts each request on a registered command bus only when the spacing rules that follow a write allow it. Because of the two-word prefetch, data moves as pairs, and a burst of `BURST_LEN` words takes `BURST_LEN/2` bus cycles of data after its WRITE.

Each bank has its own down-counters. They hold a READ until the write-to-read delay has passed after the last data pair. They hold a PRECHARGE until write recovery has passed. They hold any command to a bank that is precharging, whether the precharge was explicit or was started by an auto-precharge write. WRITEs are never held for write spacing. A WRITE that comes before the previous burst has delivered all its pairs cuts that burst short, and the block reports how many pairs the earlier burst delivered. A WRITE that comes exactly when the previous burst ends joins the two bursts with no gap.

Top module: `wr_cmd_sched`

## Requirements
- R1: After reset the command bus shows NOP (code 0), the truncation flag is low, the busy-bank error is low, and a WRITE request to any bank is accepted.
- R2: A WRITE accepted at a clock edge appears on the bus in the next cycle with its bank, column and auto-precharge bit. The pair count output shows `BURST_LEN/2`.
- R3: A READ to bank b goes on the bus no sooner than `BURST_LEN/2 + T_WTR` cycles after the last WRITE to bank b. When it is held from the start, it goes on the bus after exactly that many cycles. A READ to a bank with no write in that window goes on the bus in the next cycle.
- R4: A PRECHARGE to bank b goes on the bus no sooner than `BURST_LEN/2 + T_WR` cycles after the last WRITE to bank b. When it is held from the start, it goes on the bus after exactly that many cycles.
- R5: After a PRECHARGE to bank b, no command to bank b goes on the bus for `T_RP` cycles. While such a request waits, `err_bank_busy` is high and `req_ready` is low. Other banks are not affected.
- R6: A WRITE with auto-precharge set blocks all commands to its bank for `BURST_LEN/2 + T_WR + T_RP` cycles, and `err_bank_busy` is raised while a request to that bank waits.
- R7: A WRITE that goes on the bus g cycles after the previous WRITE, with g < `BURST_LEN/2`, raises `cmd_trunc` with `trunc_pairs` = g. When g >= `BURST_LEN/2`, `cmd_trunc` stays low.
- R8: Command codes are NOP=0, WRITE=1, READ=2, PRECHARGE=3. A NOP request is accepted at once and puts nothing on the bus. The auto-precharge flag on a READ or PRECHARGE is ignored, and `cmd_ap` is 0 for them.
- R9: While a request is held, `req_ready` is low and the bus shows NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_cmd | input | 2 | Request code (R8) |
| req_bank | input | BW | Target bank |
| req_col | input | COL_W | Starting column |
| req_ap | input | 1 | Auto-precharge flag |
| err_bank_busy | output | 1 | Request names a bank still precharging |
| cmd_out | output | 2 | Command on the bus |
| cmd_bank | output | BW | Bus bank |
| cmd_col | output | COL_W | Bus column |
| cmd_ap | output | 1 | Bus auto-precharge bit |
| cmd_pairs | output | GW | Data pairs of the issued WRITE |
| cmd_trunc | output | 1 | This WRITE cuts the previous burst short |
| trunc_pairs | output | GW | Pairs the cut burst delivered |

## Verification
The bench holds READs and PRECHARGEs straight after a write and measures the exact bus gap. A counter loaded one too high or one too low changes that gap by a cycle, and the bench sees it. It sends writes one cycle apart and two cycles apart to find the edge between cutting a burst and joining two bursts. A design with an off-by-one there would flag a join as a truncation or miss a real one. Reuse after precharge and after an auto-precharge write is checked on the same bank and on a neighbouring bank. A design that shared the timers across banks would stall the neighbour, and one that lost the auto-precharge would let the same-bank write through early.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_PRE   = 2'd3
  } cmd_e;

  // pairs of data per burst (two-word prefetch)
  function automatic int pairs_of(input int bl);
    return bl / 2;
  endfunction

  // WRITE -> READ bus distance, same bank
  function automatic int wtr_span(input int bl, input int twtr);
    return pairs_of(bl) + twtr;
  endfunction

  // WRITE -> PRECHARGE bus distance, same bank
  function automatic int wrec_span(input int bl, input int twr);
    return pairs_of(bl) + twr;
  endfunction

  // auto-precharge WRITE -> any command, same bank
  function automatic int ap_span(input int bl, input int twr, input int trp);
    return pairs_of(bl) + twr + trp;
  endfunction
endpackage

// File: rtl/wcs_bank_timer.sv
module wcs_bank_timer #(
  parameter int CW    = 4,
  parameter int RD_LD = 3,
  parameter int PR_LD = 4,
  parameter int RP_LD = 2,
  parameter int AP_LD = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_go,
  input  logic ap_go,
  input  logic pre_go,
  output logic rd_ok,
  output logic pre_ok,
  output logic idle_ok
);
  localparam logic [CW-1:0] RD_V = CW'(RD_LD);
  localparam logic [CW-1:0] PR_V = CW'(PR_LD);
  localparam logic [CW-1:0] RP_V = CW'(RP_LD);
  localparam logic [CW-1:0] AP_V = CW'(AP_LD);

  logic [CW-1:0] rd_cnt, pr_cnt, rp_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      pr_cnt <= '0;
      rp_cnt <= '0;
    end else begin
      if (wr_go)               rd_cnt <= RD_V;
      else if (rd_cnt != '0)   rd_cnt <= rd_cnt - 1'b1;
      if (wr_go)               pr_cnt <= PR_V;
      else if (pr_cnt != '0)   pr_cnt <= pr_cnt - 1'b1;
      if (pre_go)              rp_cnt <= RP_V;
      else if (ap_go)          rp_cnt <= AP_V;
      else if (rp_cnt != '0)   rp_cnt <= rp_cnt - 1'b1;
    end
  end

  assign rd_ok   = (rd_cnt == '0);
  assign pre_ok  = (pr_cnt == '0);
  assign idle_ok = (rp_cnt == '0);
endmodule

// File: rtl/wcs_burst_trk.sv
module wcs_burst_trk #(
  parameter int PAIRS = 2,
  parameter int GW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  output logic          trunc,
  output logic [GW-1:0] trunc_pairs
);
  localparam logic [GW-1:0] SAT = GW'(PAIRS);

  // cycles since the last WRITE, saturating at PAIRS (no burst in flight)
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)         gap <= SAT;
    else if (wr_go)     gap <= GW'(1);
    else if (gap < SAT) gap <= gap + 1'b1;
  end

  assign trunc       = wr_go && (gap < SAT);
  assign trunc_pairs = gap;
endmodule

// File: rtl/wr_cmd_sched.sv
module wr_cmd_sched #(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 10,
  parameter int BURST_LEN = 4,
  parameter int T_WTR     = 2,
  parameter int T_WR      = 3,
  parameter int T_RP      = 3,
  localparam int BW = $clog2(NUM_BANKS),
  localparam int GW = $clog2(BURST_LEN / 2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_cmd,
  input  logic [BW-1:0]    req_bank,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_ap,
  output logic             err_bank_busy,
  output logic [1:0]       cmd_out,
  output logic [BW-1:0]    cmd_bank,
  output logic [COL_W-1:0] cmd_col,
  output logic             cmd_ap,
  output logic [GW-1:0]    cmd_pairs,
  output logic             cmd_trunc,
  output logic [GW-1:0]    trunc_pairs
);
  import wcs_pkg::*;

  localparam int PAIRS   = pairs_of(BURST_LEN);
  localparam int RD_SPAN = wtr_span(BURST_LEN, T_WTR);
  localparam int PR_SPAN = wrec_span(BURST_LEN, T_WR);
  localparam int AP_SPAN = ap_span(BURST_LEN, T_WR, T_RP);
  localparam int CW      = $clog2(AP_SPAN + 1);

  // named internal events
  logic                 fire, fire_wr, fire_pre;
  logic [NUM_BANKS-1:0] rd_ok, pre_ok, idle_ok;
  logic                 trunc_w;
  logic [GW-1:0]        trunc_pairs_w;

  assign fire     = req_valid && req_ready;
  assign fire_wr  = fire && (req_cmd == CMD_WRITE);
  assign fire_pre = fire && (req_cmd == CMD_PRE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (req_bank == BW'(b));
    wcs_bank_timer #(
      .CW   (CW),
      .RD_LD(RD_SPAN - 1),
      .PR_LD(PR_SPAN - 1),
      .RP_LD(T_RP - 1),
      .AP_LD(AP_SPAN - 1)
    ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_go  (fire_wr && hit),
      .ap_go  (fire_wr && hit && req_ap),
      .pre_go (fire_pre && hit),
      .rd_ok  (rd_ok[b]),
      .pre_ok (pre_ok[b]),
      .idle_ok(idle_ok[b])
    );
  end

  wcs_burst_trk #(.PAIRS(PAIRS), .GW(GW)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_go      (fire_wr),
    .trunc      (trunc_w),
    .trunc_pairs(trunc_pairs_w)
  );

  always_comb begin
    unique case (req_cmd)
      CMD_WRITE: req_ready = idle_ok[req_bank];
      CMD_READ:  req_ready = idle_ok[req_bank] && rd_ok[req_bank];
      CMD_PRE:   req_ready = idle_ok[req_bank] && pre_ok[req_bank];
      default:   req_ready = 1'b1;
    endcase
  end

  assign err_bank_busy = req_valid && (req_cmd != CMD_NOP) && !idle_ok[req_bank];

  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      cmd_out     <= CMD_NOP;
      cmd_bank    <= '0;
      cmd_col     <= '0;
      cmd_ap      <= 1'b0;
      cmd_pairs   <= '0;
      cmd_trunc   <= 1'b0;
      trunc_pairs <= '0;
    end else begin
      cmd_out     <= req_cmd;
      cmd_bank    <= req_bank;
      cmd_col     <= req_col;
      cmd_ap      <= fire_wr && req_ap;
      cmd_pairs   <= fire_wr ? GW'(PAIRS) : '0;
      cmd_trunc   <= trunc_w;
      trunc_pairs <= trunc_w ? trunc_pairs_w : '0;
    end
  end
endmodule

// File: rtl/wcs_chk.sv
module wcs_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_WTR     = 2,
  parameter int T_WR      = 3,
  parameter int T_RP      = 3,
  parameter int BW        = 2,
  parameter int GW        = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_cmd,
  input logic [BW-1:0] req_bank,
  input logic          err_bank_busy,
  input logic [1:0]    cmd_out,
  input logic [BW-1:0] cmd_bank,
  input logic          cmd_ap,
  input logic [GW-1:0] cmd_pairs,
  input logic          cmd_trunc,
  input logic [GW-1:0] trunc_pairs
);
  import wcs_pkg::*;

  localparam int PAIRS   = pairs_of(BURST_LEN);
  localparam int RD_SPAN = wtr_span(BURST_LEN, T_WTR);
  localparam int PR_SPAN = wrec_span(BURST_LEN, T_WR);
  localparam int SAT     = ap_span(BURST_LEN, T_WR, T_RP);
  localparam int SW      = $clog2(SAT + 1);

  logic [SW-1:0] since_wr  [NUM_BANKS];
  logic [SW-1:0] since_pre [NUM_BANKS];
  logic [SW-1:0] since_apw [NUM_BANKS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!rst_n) begin
        since_wr[b]  <= SW'(SAT);
        since_pre[b] <= SW'(SAT);
        since_apw[b] <= SW'(SAT);
      end else begin
        if (cmd_out == CMD_WRITE && cmd_bank == BW'(b)) since_wr[b] <= SW'(1);
        else if (since_wr[b] < SW'(SAT))                since_wr[b] <= since_wr[b] + 1'b1;
        if (cmd_out == CMD_PRE && cmd_bank == BW'(b))   since_pre[b] <= SW'(1);
        else if (since_pre[b] < SW'(SAT))               since_pre[b] <= since_pre[b] + 1'b1;
        if (cmd_out == CMD_WRITE && cmd_ap && cmd_bank == BW'(b)) since_apw[b] <= SW'(1);
        else if (since_apw[b] < SW'(SAT))                         since_apw[b] <= since_apw[b] + 1'b1;
      end
    end
  end

  // R2
  wr_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cmd == CMD_WRITE) |=>
      (cmd_out == CMD_WRITE && cmd_bank == $past(req_bank)));
  // R2
  wr_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_WRITE) |-> (cmd_pairs == GW'(PAIRS)));
  // R3
  wtr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_READ) |-> (int'(since_wr[cmd_bank]) >= RD_SPAN));
  // R4
  wrec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_PRE) |-> (int'(since_wr[cmd_bank]) >= PR_SPAN));
  // R5
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out != CMD_NOP) |-> (int'(since_pre[cmd_bank]) >= T_RP));
  // R5
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_bank_busy |-> !req_ready);
  // R6
  ap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out != CMD_NOP) |-> (int'(since_apw[cmd_bank]) >= SAT));
  // R7
  trunc_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_trunc |-> (cmd_out == CMD_WRITE && int'(trunc_pairs) < PAIRS));
  // R8
  ap_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ap |-> (cmd_out == CMD_WRITE));
  // R9
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (cmd_out == CMD_NOP));
endmodule

bind wr_cmd_sched wcs_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BURST_LEN(BURST_LEN),
  .T_WTR    (T_WTR),
  .T_WR     (T_WR),
  .T_RP     (T_RP),
  .BW       (BW),
  .GW       (GW)
) u_wcs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_cmd      (req_cmd),
  .req_bank     (req_bank),
  .err_bank_busy(err_bank_busy),
  .cmd_out      (cmd_out),
  .cmd_bank     (cmd_bank),
  .cmd_ap       (cmd_ap),
  .cmd_pairs    (cmd_pairs),
  .cmd_trunc    (cmd_trunc),
  .trunc_pairs  (trunc_pairs)
);

// File: tb/test_wr_cmd_sched.sv
module test_wr_cmd_sched;
  localparam int NB = 4, CWD = 10, BL = 4, TWTR = 2, TWR = 3, TRP = 3;
  localparam int P = BL / 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [1:0]     req_cmd = 2'd0;
  logic [1:0]     req_bank = 2'd0;
  logic [CWD-1:0] req_col = '0;
  logic           req_ap = 1'b0;
  logic           err_bank_busy;
  logic [1:0]     cmd_out;
  logic [1:0]     cmd_bank;
  logic [CWD-1:0] cmd_col;
  logic           cmd_ap;
  logic [1:0]     cmd_pairs;
  logic           cmd_trunc;
  logic [1:0]     trunc_pairs;

  wr_cmd_sched #(.NUM_BANKS(NB), .COL_W(CWD), .BURST_LEN(BL),
                 .T_WTR(TWTR), .T_WR(TWR), .T_RP(TRP)) i_wr_cmd_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
    .err_bank_busy(err_bank_busy), .cmd_out(cmd_out), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cmd_pairs(cmd_pairs),
    .cmd_trunc(cmd_trunc), .trunc_pairs(trunc_pairs));

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // captured bus after a handshake
  int o_cmd, o_bank, o_col, o_ap, o_pairs, o_trunc, o_tp;
  bit saw_err, bus_noise;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // starts and ends on a negedge; returns the cycle of the handshake edge
  task automatic issue(input int c, input int b, input int col, input bit ap, output int at);
    bit first;
    first = 1'b1;
    saw_err = 1'b0;
    bus_noise = 1'b0;
    req_valid = 1'b1;
    req_cmd = 2'(c);
    req_bank = 2'(b);
    req_col = CWD'(col);
    req_ap = ap;
    forever begin
      #1;
      if (err_bank_busy) saw_err = 1'b1;
      if (!first && cmd_out != 2'd0) bus_noise = 1'b1;
      if (req_ready) break;
      first = 1'b0;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    at = cyc;
    req_valid = 1'b0;
    o_cmd = cmd_out; o_bank = cmd_bank; o_col = cmd_col; o_ap = cmd_ap;
    o_pairs = cmd_pairs; o_trunc = cmd_trunc; o_tp = trunc_pairs;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "cmd_out", cmd_out, 0);
    chk("R1", "cmd_trunc", cmd_trunc, 0);
    req_valid = 1'b1; req_cmd = 2'd1; req_bank = 2'd3;
    #1;
    chk("R1", "ready for write", req_ready, 1);
    chk("R1", "err", err_bank_busy, 0);
    req_valid = 1'b0;
    idle(1);
  endtask

  task automatic t_write_read();
    int t0, t1;
    issue(1, 1, 'h155, 1'b0, t0);
    chk("R2", "cmd", o_cmd, 1);
    chk("R2", "bank", o_bank, 1);
    chk("R2", "col", o_col, 'h155);
    chk("R2", "ap", o_ap, 0);
    chk("R2", "pairs", o_pairs, P);
    issue(2, 1, 'h10, 1'b1, t1);
    chk("R3", "write->read gap", t1 - t0, P + TWTR);
    chk("R9", "bus quiet while held", int'(bus_noise), 0);
    chk("R8", "ap ignored on read", o_ap, 0);
    chk("R3", "read cmd", o_cmd, 2);
    idle(10);
    issue(1, 1, 0, 1'b0, t0);
    issue(2, 2, 0, 1'b0, t1);
    chk("R3", "read other bank gap", t1 - t0, 1);
    idle(10);
  endtask

  task automatic t_write_pre();
    int t0, t1;
    issue(1, 2, 7, 1'b0, t0);
    issue(3, 2, 0, 1'b0, t1);
    chk("R4", "write->pre gap", t1 - t0, P + TWR);
    chk("R4", "pre cmd", o_cmd, 3);
    chk("R9", "bus quiet while held", int'(bus_noise), 0);
    idle(10);
  endtask

  task automatic t_pre_reuse();
    int t0, t1;
    issue(3, 3, 0, 1'b0, t0);
    issue(1, 3, 0, 1'b0, t1);
    chk("R5", "pre->same bank gap", t1 - t0, TRP);
    chk("R5", "err while held", int'(saw_err), 1);
    idle(10);
    issue(3, 0, 0, 1'b0, t0);
    issue(1, 1, 0, 1'b0, t1);
    chk("R5", "pre->other bank gap", t1 - t0, 1);
    chk("R5", "no err other bank", int'(saw_err), 0);
    idle(10);
  endtask

  task automatic t_autopre();
    int t0, t1;
    issue(1, 0, 3, 1'b1, t0);
    chk("R2", "ap on write", o_ap, 1);
    issue(1, 0, 4, 1'b0, t1);
    chk("R6", "ap write->same bank gap", t1 - t0, P + TWR + TRP);
    chk("R6", "err while held", int'(saw_err), 1);
    idle(12);
  endtask

  task automatic t_trunc();
    int t0, t1;
    issue(1, 1, 0, 1'b0, t0);
    chk("R7", "first write no trunc", o_trunc, 0);
    issue(1, 2, 0, 1'b0, t1);
    chk("R7", "back-to-back gap", t1 - t0, 1);
    chk("R7", "trunc flag", o_trunc, 1);
    chk("R7", "trunc pairs", o_tp, 1);
    idle(1);
    issue(1, 1, 0, 1'b0, t0);
    chk("R7", "concat gap", t0 - t1, P);
    chk("R7", "concat no trunc", o_trunc, 0);
    idle(12);
  endtask

  task automatic t_nop();
    int t0;
    issue(0, 2, 5, 1'b1, t0);
    chk("R8", "nop leaves bus idle", o_cmd, 0);
    chk("R8", "nop ap", o_ap, 0);
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_write_read();
    t_write_pre();
    t_pre_reuse();
    t_autopre();
    t_trunc();
    t_nop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule